// File: doc/BRIEF.md
# Per-Source Interrupt Status Collector

This block gathers a set of internal condition lines (eight by default) into one status register that software reads. For every line a two-bit capture code picks how that line is recorded: on its rising transition, on its falling transition, or as a live copy of its level. Edge captures stay latched until the host reads the register. Level captures simply track the line.

A mask register selects which bits the host may see and which bits may raise the interrupt. A masked bit reads as zero. The open-drain interrupt request is pulled low while any visible bit is set, and is released otherwise.

The host writes the mask register and the two capture-code registers through plain write-enable and data pins. It reads status by sampling the read data in the cycle it asserts the read strobe. All pins are plain control and status pins; the block has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register, the mask register (0 = hidden) and both capture-code registers hold all zeros, the read data is 00h and the interrupt pull is inactive.
- R2: The capture code of bit i is {hi[i], lo[i]}, taken from the high-code and low-code registers: 00 selects rising edge, 01 falling edge, 10 and 11 level.
- R3: In rising mode, a condition sampled low on one clock and high on the next sets its status bit, which is visible on the read data after that second edge. A high-to-low change does not set it.
- R4: In falling mode, a condition sampled high and then low sets its status bit, visible after that edge. A low-to-high change does not set it.
- R5: In level mode the status bit equals the condition sampled at the previous clock edge, and a read does not clear it.
- R6: An edge-captured bit stays set while no read occurs. A clock edge with the read strobe high clears it, and the read data seen during the strobe cycle is the value from before the clear.
- R7: An edge event that arrives in the same cycle as a read strobe is not lost: its bit is set after that edge.
- R8: A bit whose mask bit is 0 reads as 0. A captured event on it is kept, and it appears once the bit is unmasked.
- R9: irq_pull_o is 1 (drive the line low) exactly when some bit is both set and unmasked; otherwise it is 0 (line released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | NSRC | Condition lines, synchronous to clk |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | NSRC | Mask write data, 1 = bit visible |
| mode_hi_we_i | input | 1 | High capture-code register write enable |
| mode_hi_wdata_i | input | NSRC | High capture-code bits |
| mode_lo_we_i | input | 1 | Low capture-code register write enable |
| mode_lo_wdata_i | input | NSRC | Low capture-code bits |
| stat_rd_i | input | 1 | Read strobe; clears edge-captured bits at the clock edge |
| stat_rdata_o | output | NSRC | Masked status, valid in every cycle |
| irq_pull_o | output | 1 | 1 = pull the open-drain interrupt low |

## Verification
The hardest case to reach from the ports is an edge event landing in the very cycle the host reads. Only a precise alignment exposes whether the clear swallows it. The bench latches one event and then, in a single cycle, raises a second source together with the read strobe. It checks that the pre-clear value is seen during the strobe and that only the new event survives the edge. Masked events are checked the same way: the bench leaves an event latched while its bit is hidden, then unmasks the bit and confirms that the event appears.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic [1:0] {
    CAP_RISE   = 2'b00,
    CAP_FALL   = 2'b01,
    CAP_LEVEL  = 2'b10,
    CAP_LEVEL2 = 2'b11
  } cap_mode_e;

  function automatic logic cap_is_level(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/irqs_cfg_regs.sv
module irqs_cfg_regs #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] mask_wdata_i,
  input  logic            hi_we_i,
  input  logic [NSRC-1:0] hi_wdata_i,
  input  logic            lo_we_i,
  input  logic [NSRC-1:0] lo_wdata_i,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] hi_o,
  output logic [NSRC-1:0] lo_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      hi_o   <= '0;
      lo_o   <= '0;
    end else begin
      if (mask_we_i) mask_o <= mask_wdata_i;
      if (hi_we_i)   hi_o   <= hi_wdata_i;
      if (lo_we_i)   lo_o   <= lo_wdata_i;
    end
  end

endmodule

// File: rtl/irqs_edge_det.sv
module irqs_edge_det #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cond_i,
  output logic [NSRC-1:0] prev_o,
  output logic [NSRC-1:0] rise_o,
  output logic [NSRC-1:0] fall_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= '0;
    else        prev_o <= cond_i;
  end

  assign rise_o = cond_i & ~prev_o;
  assign fall_o = ~cond_i & prev_o;

endmodule

// File: rtl/irqs_capture.sv
module irqs_capture
  import irqs_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cond_i,
  input  logic [NSRC-1:0] rise_i,
  input  logic [NSRC-1:0] fall_i,
  input  logic [NSRC-1:0] hi_i,
  input  logic [NSRC-1:0] lo_i,
  input  logic            rd_i,
  output logic [NSRC-1:0] stat_o
);

  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    logic [1:0] code;
    logic       evt;

    assign code = {hi_i[b], lo_i[b]};

    always_comb begin
      unique case (cap_mode_e'(code))
        CAP_RISE: evt = rise_i[b];
        CAP_FALL: evt = fall_i[b];
        default:  evt = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  stat_o[b] <= 1'b0;
      else if (cap_is_level(code)) stat_o[b] <= cond_i[b];
      else                         stat_o[b] <= (stat_o[b] & ~rd_i) | evt;
    end
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cond_i,
  input  logic            mask_we_i,
  input  logic [NSRC-1:0] mask_wdata_i,
  input  logic            mode_hi_we_i,
  input  logic [NSRC-1:0] mode_hi_wdata_i,
  input  logic            mode_lo_we_i,
  input  logic [NSRC-1:0] mode_lo_wdata_i,
  input  logic            stat_rd_i,
  output logic [NSRC-1:0] stat_rdata_o,
  output logic            irq_pull_o
);

  logic [NSRC-1:0] mask_w, hi_w, lo_w;
  logic [NSRC-1:0] prev_w, rise_w, fall_w;
  logic [NSRC-1:0] stat_w;

  irqs_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .hi_we_i      (mode_hi_we_i),
    .hi_wdata_i   (mode_hi_wdata_i),
    .lo_we_i      (mode_lo_we_i),
    .lo_wdata_i   (mode_lo_wdata_i),
    .mask_o       (mask_w),
    .hi_o         (hi_w),
    .lo_o         (lo_w)
  );

  irqs_edge_det #(.NSRC(NSRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (cond_i),
    .prev_o (prev_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  irqs_capture #(.NSRC(NSRC)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (cond_i),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .hi_i   (hi_w),
    .lo_i   (lo_w),
    .rd_i   (stat_rd_i),
    .stat_o (stat_w)
  );

  assign stat_rdata_o = stat_w & mask_w;
  assign irq_pull_o   = |(stat_w & mask_w);

endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] cond_i,
  input logic [NSRC-1:0] prev,
  input logic [NSRC-1:0] hi,
  input logic [NSRC-1:0] lo,
  input logic [NSRC-1:0] stat,
  input logic            rd,
  input logic [NSRC-1:0] rdata,
  input logic            irq_pull
);

  a_r9_irq_matches_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull == (rdata != '0));

  for (genvar b = 0; b < NSRC; b++) begin : g_chk
    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ({hi[b], lo[b]} == 2'b00 && cond_i[b] && !prev[b]) |=> stat[b]);

    a_r4_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ({hi[b], lo[b]} == 2'b01 && !cond_i[b] && prev[b]) |=> stat[b]);

    a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      hi[b] |=> stat[b] == $past(cond_i[b]));

    a_r6_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi[b] && !rd && stat[b]) |=> stat[b]);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi[b] && rd && cond_i[b] == prev[b]) |=> !stat[b]);
  end

endmodule

bind irq_status_unit irq_status_unit_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cond_i   (cond_i),
  .prev     (prev_w),
  .hi       (hi_w),
  .lo       (lo_w),
  .stat     (stat_w),
  .rd       (stat_rd_i),
  .rdata    (stat_rdata_o),
  .irq_pull (irq_pull_o)
);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cond = '0;
  logic       mask_we = 1'b0, hi_we = 1'b0, lo_we = 1'b0, rd = 1'b0;
  logic [7:0] mask_wd = '0, hi_wd = '0, lo_wd = '0;
  logic [7:0] rdata;
  logic       irq;
  int         vectors = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  irq_status_unit #(.NSRC(8)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .cond_i          (cond),
    .mask_we_i       (mask_we),
    .mask_wdata_i    (mask_wd),
    .mode_hi_we_i    (hi_we),
    .mode_hi_wdata_i (hi_wd),
    .mode_lo_we_i    (lo_we),
    .mode_lo_wdata_i (lo_wd),
    .stat_rd_i       (rd),
    .stat_rdata_o    (rdata),
    .irq_pull_o      (irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] m, input logic [7:0] h, input logic [7:0] l);
    mask_we = 1'b1; mask_wd = m;
    hi_we = 1'b1; hi_wd = h;
    lo_we = 1'b1; lo_wd = l;
    tick();
    mask_we = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
  endtask

  task automatic do_read();
    rd = 1'b1;
    tick();
    rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    wr_cfg(8'hFF, 8'h00, 8'h00);
    chk("R1 no stale status", rdata, 8'h00);
  endtask

  task automatic t_rise();
    wr_cfg(8'hFF, 8'h00, 8'h00);
    cond[0] = 1'b1;
    tick();
    chk("R3 rise captured", rdata, 8'h01);
    chk("R9 irq on", {7'b0, irq}, 8'h01);
    tick(); tick();
    chk("R6 holds without read", rdata, 8'h01);
    rd = 1'b1;
    chk("R6 value during strobe", rdata, 8'h01);
    tick();
    rd = 1'b0;
    chk("R6 cleared by read", rdata, 8'h00);
    chk("R9 irq released", {7'b0, irq}, 8'h00);
    cond[0] = 1'b0;
    tick();
    chk("R3 fall ignored in rise mode", rdata, 8'h00);
  endtask

  task automatic t_fall();
    wr_cfg(8'hFF, 8'h00, 8'h02);
    cond[1] = 1'b1;
    tick();
    chk("R4 rise ignored in fall mode", rdata, 8'h00);
    cond[1] = 1'b0;
    tick();
    chk("R4 fall captured", rdata, 8'h02);
    do_read();
    chk("R4 cleared", rdata, 8'h00);
  endtask

  task automatic t_level();
    wr_cfg(8'hFF, 8'h0C, 8'h08);
    cond[2] = 1'b1;
    cond[3] = 1'b1;
    tick();
    chk("R2 codes 10 and 11 are level", rdata, 8'h0C);
    do_read();
    chk("R5 level survives read", rdata, 8'h0C);
    cond[2] = 1'b0;
    tick();
    chk("R5 level follows low", rdata, 8'h08);
    cond[3] = 1'b0;
    tick();
    chk("R5 level all low", rdata, 8'h00);
  endtask

  task automatic t_same_cycle();
    wr_cfg(8'hFF, 8'h00, 8'h00);
    cond[0] = 1'b1;
    tick();
    chk("R7 first event", rdata, 8'h01);
    cond[4] = 1'b1;
    rd = 1'b1;
    chk("R7 pre-clear value", rdata, 8'h01);
    tick();
    rd = 1'b0;
    chk("R7 new event kept", rdata, 8'h10);
    do_read();
    chk("R7 drained", rdata, 8'h00);
    cond = '0;
    tick();
  endtask

  task automatic t_mask();
    wr_cfg(8'hFE, 8'h00, 8'h00);
    cond[0] = 1'b1;
    tick();
    chk("R8 masked reads zero", rdata, 8'h00);
    chk("R9 masked no irq", {7'b0, irq}, 8'h00);
    wr_cfg(8'hFF, 8'h00, 8'h00);
    chk("R8 unmask reveals", rdata, 8'h01);
    chk("R9 irq after unmask", {7'b0, irq}, 8'h01);
    do_read();
    cond = '0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_rise();
    t_fall();
    t_level();
    t_same_cycle();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule